// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital control for a successive-approximation analog-to-digital converter. Software writes a control word holding a repeat-mode bit and a 5-bit channel code. From each write the sequencer decides whether to start one conversion, run conversions back to back, abort the conversion in flight, or switch the converter off. It wakes the converter, pulses a start strobe to the converter core and waits for its done pulse. It then latches the 10-bit result and raises a completion flag.

The channel code is decoded into a one-hot analog multiplexer select. The select is held at zero whenever the converter is unpowered, which isolates every input. Code 31 is an explicit off command. In single mode the converter powers itself down after each conversion. In repeat mode each conversion is followed at once by the next, until a later write changes the mode or turns the converter off.

Top module: `adc_conv_seq`

## Requirements
- R1: With the repeat bit clear, a write whose channel code is not 31 produces exactly one conversion. Its `convData` is latched into `result` and `complete` goes high.
- R2: `powerEn` rises in the cycle after a write (code not 31). `convStart` pulses one cycle later. `powerEn` falls in the cycle after a single-mode result is latched.
- R3: With the repeat bit set, a new one-cycle `convStart` pulse is issued in the cycle right after each accepted `convDone`.
- R4: A write during a conversion, or in the same cycle as `convDone`, aborts that conversion. Its result is never latched. A conversion for the new write follows.
- R5: A write with code 31 powers the converter off in the next cycle and drives `muxSel` to zero. It stops repeat mode without one more conversion. Any `convDone` that arrives afterwards is ignored.
- R6: `muxSel` decoding: codes 0 to 7 drive bits 0 to 7. Code 11 drives bit 8 and code 12 drives bit 9. Code 13 (bandgap) drives bit 10. Code 29 (high reference) drives bit 11 and code 30 (low reference) drives bit 12. Every other code drives all zeros. `muxSel` is all zeros while `powerEn` is low.
- R7: An unused or reserved code (8 to 10, 14 to 28) still runs one conversion and sets `complete`.
- R8: `complete` is cleared by any write or by a `resultRd` pulse. If a result is latched in the same cycle as `resultRd`, `complete` stays set.
- R9: After reset `powerEn`, `convStart`, `muxSel`, `result` and `complete` are all zero.
- R10: Once repeat mode has stopped, no conversion starts again until a new write arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Control word write strobe |
| wrCont | input | 1 | Repeat-mode bit of the written word |
| wrChan | input | 5 | Channel code of the written word |
| resultRd | input | 1 | Result read strobe, clears `complete` |
| convDone | input | 1 | Conversion finished pulse from the converter core |
| convData | input | 10 | Conversion value, valid with `convDone` |
| convStart | output | 1 | One-cycle start pulse to the converter core |
| powerEn | output | 1 | Converter power enable |
| muxSel | output | 13 | One-hot analog input select |
| result | output | 10 | Last latched conversion value |
| complete | output | 1 | Conversion-complete flag |

## Verification
The bench attacks the abort paths first. It sends a second write midway through a conversion, sends a write in the very cycle the old done pulse arrives, and sends an off write while a conversion is pending. A design that let the stale done through would latch an extra result with the wrong channel tag, and the scoreboard reports that as an unexpected item. Repeat mode is stopped by an off write right after a result. A design that finished one more conversion, or restarted on its own, would show extra start pulses during the quiet window. The bench also walks every channel code through the decoder, and it lands a read on the same cycle as a latch, where a wrong priority would leave the flag cleared.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CHAN_W = 5;
  localparam int SEL_N  = 13;
  localparam logic [CHAN_W-1:0] CHAN_OFF = '1;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAKE   = 2'd1,
    ST_LAUNCH = 2'd2,
    ST_BUSY   = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic latchRes;
    logic powered;
  } seqStrobe_t;

  function automatic logic [SEL_N-1:0] decodeChan(input logic [CHAN_W-1:0] code);
    logic [SEL_N-1:0] sel;
    sel = '0;
    if (code < CHAN_W'(8)) begin
      sel[code[2:0]] = 1'b1;
    end else begin
      case (code)
        CHAN_W'(11): sel[8]  = 1'b1;
        CHAN_W'(12): sel[9]  = 1'b1;
        CHAN_W'(13): sel[10] = 1'b1;
        CHAN_W'(29): sel[11] = 1'b1;
        CHAN_W'(30): sel[12] = 1'b1;
        default:     sel     = '0;
      endcase
    end
    return sel;
  endfunction
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic       wrOff,
  input  logic       contMode,
  input  logic       convDone,
  output seqStrobe_t stb,
  output logic       convStart
);
  seqState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    if (regWr) begin
      stateNxt = wrOff ? ST_IDLE : ST_WAKE;
    end else begin
      case (state)
        ST_WAKE:   stateNxt = ST_LAUNCH;
        ST_LAUNCH: stateNxt = ST_BUSY;
        ST_BUSY:   if (convDone) stateNxt = contMode ? ST_LAUNCH : ST_IDLE;
        default:   stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stb.loadCfg  = regWr;
    stb.latchRes = (state == ST_BUSY) && convDone && !regWr;
    stb.powered  = (state != ST_IDLE);
  end

  assign convStart = (state == ST_LAUNCH);
endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic              wrCont,
  input  logic [CHAN_W-1:0] wrChan,
  input  logic              resultRd,
  input  logic [RES_W-1:0]  convData,
  output logic              contMode,
  output logic [SEL_N-1:0]  muxSel,
  output logic [RES_W-1:0]  result,
  output logic              complete
);
  logic [CHAN_W-1:0] chanReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanReg  <= CHAN_OFF;
      contMode <= 1'b0;
    end else if (stb.loadCfg) begin
      chanReg  <= wrChan;
      contMode <= wrCont && (wrChan != CHAN_OFF);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result   <= '0;
      complete <= 1'b0;
    end else begin
      if (stb.latchRes) result <= convData;
      if (stb.latchRes)                  complete <= 1'b1;
      else if (stb.loadCfg || resultRd)  complete <= 1'b0;
    end
  end

  assign muxSel = stb.powered ? decodeChan(chanReg) : '0;
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              wrCont,
  input  logic [CHAN_W-1:0] wrChan,
  input  logic              resultRd,
  input  logic              convDone,
  input  logic [RES_W-1:0]  convData,
  output logic              convStart,
  output logic              powerEn,
  output logic [SEL_N-1:0]  muxSel,
  output logic [RES_W-1:0]  result,
  output logic              complete
);
  seqStrobe_t stb;
  logic       contMode;

  adc_seq_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWr    (regWr),
    .wrOff    (wrChan == CHAN_OFF),
    .contMode (contMode),
    .convDone (convDone),
    .stb      (stb),
    .convStart(convStart)
  );

  adc_seq_dp #(.RES_W(RES_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrCont   (wrCont),
    .wrChan   (wrChan),
    .resultRd (resultRd),
    .convData (convData),
    .contMode (contMode),
    .muxSel   (muxSel),
    .result   (result),
    .complete (complete)
  );

  assign powerEn = stb.powered;
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk
  import adc_seq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic [CHAN_W-1:0] wrChan,
  input logic              convDone,
  input logic              convStart,
  input logic              powerEn,
  input logic [SEL_N-1:0]  muxSel,
  input logic              complete
);
  AST_FLAG_FROM_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(complete) |-> $past(convDone)); // R1
  AST_WRITE_WAKES: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && wrChan != CHAN_OFF) |=> (powerEn && !convStart)); // R2
  AST_START_AFTER_POWER: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> $past(powerEn)); // R2
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart); // R3
  AST_OFF_POWERS_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && wrChan == CHAN_OFF) |=> (!powerEn && !convStart)); // R5
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(muxSel)); // R6
  AST_SEL_ISOLATED: assert property (@(posedge clk) disable iff (!rstN)
    !powerEn |-> (muxSel == '0)); // R6
  AST_WRITE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    regWr |=> !complete); // R8
endmodule

bind adc_conv_seq adc_conv_seq_chk i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWr    (regWr),
  .wrChan   (wrChan),
  .convDone (convDone),
  .convStart(convStart),
  .powerEn  (powerEn),
  .muxSel   (muxSel),
  .complete (complete)
);

// File: tb/test_adc_conv_seq.sv
`timescale 1ns/1ps
module test_adc_conv_seq;
  localparam int LAT = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic        wrCont = 1'b0;
  logic [4:0]  wrChan = 5'd0;
  logic        resultRd = 1'b0;
  logic        convDone = 1'b0;
  logic [9:0]  convData = '0;
  logic        convStart, powerEn, complete;
  logic [12:0] muxSel;
  logic [9:0]  result;

  int checks = 0;
  int fails = 0;
  int startCount = 0;
  int popCount = 0;
  int expQ[$];

  always #2 clk = ~clk;

  adc_conv_seq i_adc_conv_seq (
    .clk(clk), .rstN(rstN), .regWr(regWr), .wrCont(wrCont), .wrChan(wrChan),
    .resultRd(resultRd), .convDone(convDone), .convData(convData),
    .convStart(convStart), .powerEn(powerEn), .muxSel(muxSel),
    .result(result), .complete(complete)
  );

  // behavioural converter core: result = {source index, sequence}
  int stubCnt = 0;
  logic [5:0] seqNo = 6'd1;
  always @(posedge clk) begin
    if (convStart) begin
      stubCnt  <= LAT;
      convDone <= 1'b0;
    end else if (stubCnt == 1) begin
      int src;
      src = 15;
      for (int i = 0; i < 13; i++) if (muxSel[i]) src = i;
      convDone <= 1'b1;
      convData <= {src[3:0], seqNo};
      seqNo    <= (seqNo == 6'd63) ? 6'd1 : seqNo + 6'd1;
      stubCnt  <= 0;
    end else begin
      if (stubCnt != 0) stubCnt <= stubCnt - 1;
      convDone <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected one-hot index from the R6 table; -1 means unused/reserved
  function automatic int expIdx(input int code);
    if (code < 8) return code;
    case (code)
      11: return 8;
      12: return 9;
      13: return 10;
      29: return 11;
      30: return 12;
      default: return -1;
    endcase
  endfunction

  // monitor: every new result value is one latched conversion
  logic [9:0] lastRes = '0;
  always @(negedge clk) begin
    if (rstN) begin
      if (convStart) startCount++;
      if (result !== lastRes) begin
        lastRes = result;
        popCount++;
        if (expQ.size() == 0) begin
          check(1'b0, "R4 unexpected result", int'(result), -1);
        end else begin
          int e;
          e = expQ.pop_front();
          check(complete === 1'b1, "R1 complete on latch", int'(complete), 1);
          if (e >= 0) check(int'(result[9:6]) == e, "R6 result channel", int'(result[9:6]), e);
        end
      end
    end
  end

  // called at a negedge; write is sampled at the next posedge
  task automatic doWrite(input bit cont, input int chan);
    regWr = 1'b1; wrCont = cont; wrChan = chan[4:0];
    @(negedge clk);
    regWr = 1'b0; wrCont = 1'b0;
  endtask

  task automatic waitPops(input int target);
    for (int i = 0; i < 200 && popCount < target; i++) @(negedge clk);
    check(popCount == target, "R1 result count", popCount, target);
  endtask

  task automatic waitDoneHigh();
    for (int i = 0; i < 200 && convDone !== 1'b1; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(powerEn == 0 && convStart == 0 && complete == 0, "R9 reset controls", int'(powerEn), 0);
    check(muxSel == 0 && result == 0, "R9 reset data", int'(muxSel), 0);

    // R1/R2 single conversion timing
    expQ.push_back(3);
    doWrite(1'b0, 3);
    check(powerEn == 1 && convStart == 0, "R2 wake before start", int'(convStart), 0);
    @(negedge clk);
    check(convStart == 1, "R2 start one cycle after wake", int'(convStart), 1);
    waitPops(1);
    check(powerEn == 0, "R2 power down after single", int'(powerEn), 0);
    check(complete == 1, "R1 complete set", int'(complete), 1);

    // R8 read clears, write clears
    resultRd = 1'b1; @(negedge clk); resultRd = 1'b0;
    check(complete == 0, "R8 read clears", int'(complete), 0);
    expQ.push_back(4);
    doWrite(1'b0, 4);
    waitPops(2);
    doWrite(1'b0, 31);
    check(complete == 0, "R8 write clears", int'(complete), 0);

    // R8 read on the latch cycle keeps flag
    expQ.push_back(5);
    doWrite(1'b0, 5);
    waitDoneHigh();
    resultRd = 1'b1; @(negedge clk); resultRd = 1'b0;
    check(complete == 1, "R8 latch beats read", int'(complete), 1);
    waitPops(3);

    // R4 abort mid-conversion with a new channel
    base = popCount;
    doWrite(1'b0, 2);
    repeat (4) @(negedge clk);
    expQ.push_back(6);
    doWrite(1'b0, 6);
    waitPops(base + 1);
    repeat (20) @(negedge clk);
    check(popCount == base + 1, "R4 aborted result dropped", popCount, base + 1);

    // R4 write landing on the done cycle
    base = popCount;
    doWrite(1'b0, 1);
    waitDoneHigh();
    expQ.push_back(7);
    doWrite(1'b0, 7);
    waitPops(base + 1);
    repeat (20) @(negedge clk);
    check(popCount == base + 1 && expQ.size() == 0, "R4 same-cycle abort", popCount, base + 1);

    // R5 off during single conversion: stale done ignored
    base = popCount;
    doWrite(1'b0, 0);
    repeat (3) @(negedge clk);
    doWrite(1'b0, 31);
    check(powerEn == 0 && muxSel == 0, "R5 off isolates", int'(muxSel), 0);
    repeat (20) @(negedge clk);
    check(popCount == base, "R5 stale done ignored", popCount, base);

    // R3 continuous, then R5 stop, then R10 quiet
    base = popCount;
    for (int k = 0; k < 4; k++) expQ.push_back(12);
    doWrite(1'b1, 30);
    waitDoneHigh();
    @(negedge clk);
    check(convStart == 1, "R3 restart after done", int'(convStart), 1);
    waitPops(base + 4);
    doWrite(1'b0, 31);
    check(powerEn == 0, "R5 off stops repeat", int'(powerEn), 0);
    startCount = 0;
    repeat (60) @(negedge clk);
    check(startCount == 0, "R10 no restart without write", startCount, 0);
    check(popCount == base + 4, "R5 no extra conversion", popCount, base + 4);

    // R10 new write resumes repeat mode, then a mode-change write ends it
    base = popCount;
    expQ.push_back(1); expQ.push_back(1);
    doWrite(1'b1, 1);
    waitPops(base + 2);
    expQ.push_back(9);
    doWrite(1'b0, 12);
    waitPops(base + 3);
    repeat (20) @(negedge clk);
    check(popCount == base + 3, "R10 single after repeat", popCount, base + 3);

    // R6/R7 walk every code except off
    for (int c = 0; c < 31; c++) begin
      int e;
      e = expIdx(c);
      base = popCount;
      expQ.push_back(e);
      doWrite(1'b0, c);
      if (e >= 0) check(muxSel == (13'd1 << e), $sformatf("R6 decode code %0d", c), int'(muxSel), 1 << e);
      else        check(muxSel == 13'd0, $sformatf("R6 unused code %0d", c), int'(muxSel), 0);
      waitPops(base + 1);
      if (e < 0) check(complete == 1, "R7 unused code converts", int'(complete), 1);
    end

    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R1 scoreboard drained", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule